// File: doc/BRIEF.md
# Adapter Transmit Grant Checker

This block sits on the adapter side of a shared-memory packet switch and decides whether the packet at the head of a transmit queue may be sent now. It holds a table of output-queue grant bits, one for each pair of switch output and priority. Whenever a packet comes back from the switch, the table is reloaded from that packet's 16-bit grant field. The block also registers a per-priority memory grant pin bus on every clock.

A request carries a priority, a destination bitmap and a monocast flag. The permit output is combinational from the request and the stored state. The memory grant bit for the request priority must be set for any send. A monocast request also needs the table bit for its single destination at that priority. A multicast request looks only at the memory grant.

Top module: `tx_grant_checker`

## Requirements
- R1: While rst_ni is low, and after it is released, the table and the registered memory grant are all zero, so permit_o is 0 until they are loaded.
- R2: When hdr_valid_i is high at a rising clock edge, the grant table takes hdr_bits_i. The new contents affect permit_o only from the cycle after the strobe. While hdr_valid_i is low, the table holds its value.
- R3: Table bit index p*4+o (the priority in the upper two bits of the index) grants priority p toward output o.
- R4: mem_grant_i is sampled into a register at every rising edge, and bit p is the memory grant for priority p. A change on the pins affects permit_o in the cycle after the edge that samples it.
- R5: permit_o is 0 whenever the registered memory grant bit for req_prio_i is 0, whatever the table holds.
- R6: A monocast request (req_mono_i=1) whose req_dest_i has exactly one bit set, at position o, is permitted only if the memory grant bit for the priority and table bit p*4+o are both set.
- R7: A multicast request (req_mono_i=0) is permitted exactly when the memory grant bit for its priority is set. The table has no effect on it.
- R8: A monocast request whose req_dest_i has zero bits set, or more than one bit set, is refused.
- R9: permit_o responds to req_prio_i, req_dest_i and req_mono_i in the same cycle, with no register in that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | Strobe: a packet from the switch carries a grant field |
| hdr_bits_i | input | 16 | Grant field from header bytes 1 and 2, bit p*4+o |
| mem_grant_i | input | 4 | Memory grant pins, one per priority |
| req_prio_i | input | 2 | Priority of the candidate packet |
| req_dest_i | input | 4 | Destination bitmap of the candidate packet |
| req_mono_i | input | 1 | 1 = monocast, 0 = multicast |
| permit_o | output | 1 | Transmit permitted |

## Verification
A table reload and a permit decision can fall in the same cycle. The memory grant pins can also change in a cycle where a request is being evaluated. The bench drives a header strobe that opens or closes the requested bit in the same cycle as a monocast request. It expects the old table value in that cycle and the new value in the next cycle. It also toggles mem_grant_i together with the requests. A behavioural model that updates only at clock edges is compared with permit_o in every cycle, across directed sweeps and a long random stretch that mixes both events.

// File: rtl/tx_grant_pkg.sv
package tx_grant_pkg;
  parameter int unsigned N_OUT_DEF  = 4;
  parameter int unsigned N_PRIO_DEF = 4;
endpackage

// File: rtl/grant_table.sv
module grant_table #(
  parameter int unsigned N_OUT  = 4,
  parameter int unsigned N_PRIO = 4,
  localparam int unsigned TBL_W = N_OUT * N_PRIO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [TBL_W-1:0] bits_i,
  output logic [TBL_W-1:0] tbl_o
);
  logic [TBL_W-1:0] tbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tbl_q <= '0;
    else if (upd_i) tbl_q <= bits_i;
  end

  assign tbl_o = tbl_q;

  // R2
  table_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> tbl_q == $past(bits_i));
  // R2
  table_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(tbl_q));
endmodule

// File: rtl/dest_encoder.sv
module dest_encoder #(
  parameter int unsigned N_OUT = 4,
  localparam int unsigned IDX_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic [N_OUT-1:0] dest_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  int unsigned ones;

  always_comb begin
    ones  = 0;
    idx_o = '0;
    for (int i = 0; i < N_OUT; i++) begin
      if (dest_i[i]) begin
        ones  = ones + 1;
        idx_o = IDX_W'(i);
      end
    end
    valid_o = (ones == 1);
  end

  // R8
  enc_points_at_set_bit_chk: assert final (!valid_o || dest_i[idx_o]);
endmodule

// File: rtl/permit_logic.sv
module permit_logic #(
  parameter int unsigned N_OUT  = 4,
  parameter int unsigned N_PRIO = 4,
  localparam int unsigned TBL_W = N_OUT * N_PRIO,
  localparam int unsigned IDX_W = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int unsigned PRIO_W = (N_PRIO > 1) ? $clog2(N_PRIO) : 1
) (
  input  logic [TBL_W-1:0]  tbl_i,
  input  logic [N_PRIO-1:0] mem_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic              mono_i,
  input  logic              dest_ok_i,
  input  logic [IDX_W-1:0]  dest_idx_i,
  output logic              permit_o
);
  logic [N_OUT-1:0] row [N_PRIO];

  for (genvar p = 0; p < N_PRIO; p++) begin : g_row
    assign row[p] = tbl_i[p*N_OUT +: N_OUT];
  end

  logic [N_OUT-1:0] sel_row;
  logic             mem_ok;
  logic             q_ok;

  always_comb begin
    sel_row = row[prio_i];
    mem_ok  = mem_i[prio_i];
    q_ok    = dest_ok_i && sel_row[dest_idx_i];
    permit_o = mem_ok && (!mono_i || q_ok);
  end
endmodule

// File: rtl/tx_grant_checker.sv
module tx_grant_checker
  import tx_grant_pkg::*;
#(
  parameter int unsigned N_OUT  = N_OUT_DEF,
  parameter int unsigned N_PRIO = N_PRIO_DEF,
  localparam int unsigned TBL_W = N_OUT * N_PRIO,
  localparam int unsigned IDX_W = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int unsigned PRIO_W = (N_PRIO > 1) ? $clog2(N_PRIO) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_valid_i,
  input  logic [TBL_W-1:0]  hdr_bits_i,
  input  logic [N_PRIO-1:0] mem_grant_i,
  input  logic [PRIO_W-1:0] req_prio_i,
  input  logic [N_OUT-1:0]  req_dest_i,
  input  logic              req_mono_i,
  output logic              permit_o
);
  logic [TBL_W-1:0]  tbl;
  logic [N_PRIO-1:0] mem_q;
  logic              dest_ok;
  logic [IDX_W-1:0]  dest_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else         mem_q <= mem_grant_i;
  end

  grant_table #(.N_OUT(N_OUT), .N_PRIO(N_PRIO)) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (hdr_valid_i),
    .bits_i (hdr_bits_i),
    .tbl_o  (tbl)
  );

  dest_encoder #(.N_OUT(N_OUT)) u_enc (
    .dest_i  (req_dest_i),
    .valid_o (dest_ok),
    .idx_o   (dest_idx)
  );

  permit_logic #(.N_OUT(N_OUT), .N_PRIO(N_PRIO)) u_permit (
    .tbl_i      (tbl),
    .mem_i      (mem_q),
    .prio_i     (req_prio_i),
    .mono_i     (req_mono_i),
    .dest_ok_i  (dest_ok),
    .dest_idx_i (dest_idx),
    .permit_o   (permit_o)
  );

  // R4
  mem_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> mem_q == $past(mem_grant_i));
  // R5
  no_mem_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_q[req_prio_i] |-> !permit_o);
  // R8
  mono_bad_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_mono_i && $countones(req_dest_i) != 1) |-> !permit_o);
  // R6
  mono_needs_queue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_mono_i && permit_o) |-> (tbl[req_prio_i*N_OUT + 32'(dest_idx)] && req_dest_i[dest_idx]));
endmodule

// File: tb/tx_grant_checker_tb.sv
`timescale 1ns/1ps
module tx_grant_checker_tb;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        hdr_valid = 0;
  logic [15:0] hdr_bits = '0;
  logic [3:0]  mem_grant = '0;
  logic [1:0]  req_prio = '0;
  logic [3:0]  req_dest = '0;
  logic        req_mono = 0;
  logic        permit;

  int n_cmp = 0;
  int n_bad = 0;

  logic [15:0] tbl_ref = '0;
  logic [3:0]  mem_ref = '0;

  always #2.5 clk = ~clk;

  tx_grant_checker u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .hdr_valid_i(hdr_valid), .hdr_bits_i(hdr_bits),
    .mem_grant_i(mem_grant), .req_prio_i(req_prio), .req_dest_i(req_dest),
    .req_mono_i(req_mono), .permit_o(permit)
  );

  // reference model: state changes only at edges
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_ref = '0;
      mem_ref = '0;
    end else begin
      mem_ref = mem_grant;
      if (hdr_valid) tbl_ref = hdr_bits;
    end
  end

  function automatic logic expect_permit();
    int ones = 0;
    int pos = 0;
    for (int i = 0; i < 4; i++) if (req_dest[i]) begin ones++; pos = i; end
    if (!mem_ref[req_prio]) return 1'b0;
    if (!req_mono) return 1'b1;
    if (ones != 1) return 1'b0;
    return tbl_ref[int'(req_prio)*4 + pos];
  endfunction

  function automatic string auto_tag();
    int ones = 0;
    for (int i = 0; i < 4; i++) if (req_dest[i]) ones++;
    if (!rst_ni) return "R1";
    if (!mem_ref[req_prio]) return "R5";
    if (!req_mono) return "R7";
    if (ones != 1) return "R8";
    return "R6";
  endfunction

  task automatic compare(input string tag);
    logic e;
    e = expect_permit();
    n_cmp++;
    if (permit !== e) begin
      n_bad++;
      $display("FAIL %s: permit actual=%b expected=%b (prio=%0d dest=%b mono=%b)",
               tag, permit, e, req_prio, req_dest, req_mono);
    end
  endtask

  // drive at negedge, compare 1 ns later, i.e. away from the rising edge
  task automatic step(input logic hv, input logic [15:0] hb, input logic [3:0] mg,
                      input logic [1:0] p, input logic [3:0] d, input logic m,
                      input string tag);
    @(negedge clk);
    hdr_valid = hv; hdr_bits = hb; mem_grant = mg;
    req_prio = p; req_dest = d; req_mono = m;
    #1;
    compare(tag == "" ? auto_tag() : tag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset holds everything closed even with pins and header active
    step(1, 16'hFFFF, 4'hF, 0, 4'b0001, 0, "R1");
    step(1, 16'hFFFF, 4'hF, 2, 4'b0100, 1, "R1");
    @(negedge clk); rst_ni = 1;
    step(0, '0, 4'h0, 0, 4'b0001, 0, "R1");
    // R5: no memory grant, multicast refused
    step(0, '0, 4'h0, 1, 4'b1111, 0, "R5");
    // R4: pins open, visible one cycle later
    step(0, '0, 4'hF, 1, 4'b1111, 0, "R4");
    step(0, '0, 4'hF, 1, 4'b1111, 0, "R4");
    // R6: empty table refuses monocast
    step(0, '0, 4'hF, 1, 4'b0010, 1, "R6");
    // R2: header in same cycle as request: old table, then new
    step(1, 16'hFFFF, 4'hF, 1, 4'b0010, 1, "R2");
    step(0, 16'h0000, 4'hF, 1, 4'b0010, 1, "R2");
    // R2: close in same cycle, still open this cycle
    step(1, 16'h0000, 4'hF, 3, 4'b1000, 1, "R2");
    step(0, 16'hFFFF, 4'hF, 3, 4'b1000, 1, "R2");
    // R3: walk single bit through table, probe every (p,o)
    for (int b = 0; b < 16; b++) begin
      step(1, 16'(1 << b), 4'hF, 0, 4'b0001, 0, "R7");
      for (int p = 0; p < 4; p++)
        for (int o = 0; o < 4; o++)
          step(0, '0, 4'hF, 2'(p), 4'(1 << o), 1, "R3");
    end
    // R8: zero and multi-bit destinations refused with table fully open
    step(1, 16'hFFFF, 4'hF, 0, 4'b0000, 1, "R8");
    step(0, '0, 4'hF, 0, 4'b0000, 1, "R8");
    step(0, '0, 4'hF, 2, 4'b0110, 1, "R8");
    step(0, '0, 4'hF, 3, 4'b1111, 1, "R8");
    // R7: multicast ignores an empty table
    step(1, 16'h0000, 4'hF, 0, 4'b0011, 0, "R7");
    step(0, '0, 4'b0101, 2, 4'b0011, 0, "R7");
    step(0, '0, 4'b0101, 2, 4'b1100, 0, "R7");
    // R5: per-priority memory grant gates open table
    step(1, 16'hFFFF, 4'b1010, 0, 4'b0001, 1, "R5");
    step(0, '0, 4'b1010, 0, 4'b0001, 1, "R5");
    step(0, '0, 4'b1010, 1, 4'b0001, 1, "R5");
    // R9: request change alone moves permit in the same cycle
    step(0, '0, 4'b1010, 0, 4'b0001, 1, "R9");
    step(0, '0, 4'b1010, 3, 4'b0001, 1, "R9");
    // random mix of header reloads, pin changes and requests
    for (int k = 0; k < 3000; k++)
      step(($urandom % 3) == 0, 16'($urandom), 4'($urandom), 2'($urandom),
           ($urandom % 2) ? 4'(1 << ($urandom % 4)) : 4'($urandom),
           1'($urandom), "");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule